// File: doc/BRIEF.md
# Iterative Signed Multiply/Divide Unit with Result Pair

A multicycle arithmetic unit that accepts two 32-bit two's complement operands and either multiplies them or divides the first by the second. The results go into two 32-bit result registers, `hi` and `lo`. A multiply leaves the upper half of its 64-bit product in `hi` and the lower half in `lo`. A divide leaves the remainder in `hi` and the quotient in `lo`. The surrounding pipeline reads both registers at any time and watches `busy` to know when fresh results are present.

Internally both operands are first reduced to magnitudes. The multiply then runs a right-shifting add-when-bit-set loop over a double-width accumulator. The divide runs a restoring loop: shift left, subtract on trial, keep the difference when it is non-negative. Each of the 32 iterations takes one cycle. One further cycle restores the signs and writes `hi`/`lo`. The divide never raises an error. A zero divisor or the most-negative-by-minus-one case simply leaves whatever the datapath produced.

The controller has three named states:
- `ST_IDLE` waits for work. On `start` it loads the operands and moves to `ST_ITER`.
- `ST_ITER` performs one iteration per cycle. After the 32nd iteration it moves to `ST_FIX`.
- `ST_FIX` applies the sign correction, writes `hi`/`lo` and returns to `ST_IDLE`.

Top module: `muldiv_unit`

## Requirements
- R1: After reset `busy` is 0 and both `hi` and `lo` read 0.
- R2: With `op_div` = 0, a completed operation leaves {`hi`,`lo`} equal to the exact signed 64-bit product of `opa` and `opb`, with the upper 32 bits in `hi`.
- R3: With `op_div` = 1, a completed operation leaves in `lo` the quotient `opa`/`opb`, truncated toward zero.
- R4: With `op_div` = 1 and a nonzero divisor, `hi` holds the remainder. It is zero or carries the sign of `opa`, and `lo`*`opb` + `hi` equals `opa`.
- R5: A `start` seen while `busy` is 0 is accepted. `busy` reads 1 from the next cycle, stays 1 for exactly 33 cycles (32 iterations plus one sign-fix cycle), and falls on the same clock edge that writes `hi` and `lo`.
- R6: A `start` seen while `busy` is 1 is ignored. This holds even in the final sign-fix cycle. The running operation's results are unchanged, and `busy` is 0 in the cycle after the run ends.
- R7: A zero divisor never traps. `hi` becomes `opa`. `lo` becomes all ones (0xFFFFFFFF) when `opa` is non-negative, and 1 when `opa` is negative. This is the all-ones magnitude quotient negated because the operand signs differ.
- R8: Dividing 0x80000000 by 0xFFFFFFFF (−1) never traps and gives `lo` = 0x80000000 and `hi` = 0.
- R9: `hi` and `lo` change only on the completion edge. While a run is in progress they keep the previous results.
- R10: Operands and `op_div` are sampled only in the accepting cycle. Later changes on those inputs do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation; honoured only while idle |
| op_div | input | 1 | Operation select: 0 multiply, 1 divide |
| opa | input | 32 | First operand (multiplicand or dividend), signed |
| opb | input | 32 | Second operand (multiplier or divisor), signed |
| busy | output | 1 | High while an accepted operation is in progress |
| hi | output | 32 | Product upper word, or divide remainder |
| lo | output | 32 | Product lower word, or divide quotient |

## Verification
The overlap of interest is a new `start` arriving in the same cycle as the sign-fix cycle. In that cycle the unit is still busy but is writing `hi`/`lo` and returning to idle. The bench raises `start` with different operands exactly in the 33rd busy cycle, and also in the middle of the iteration phase. It then requires that `busy` reads 0 on the following cycle and that `hi`/`lo` match the first operation's model results. The bench also changes the operand inputs throughout every run. Each result is compared with a model built on 64-bit signed `*`, `/` and `%`, with zero divisors and the most-negative-by-minus-one case handled as the requirements state.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } mdu_state_e;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int ITERS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic load,
    output logic step,
    output logic fin
);

    localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

    mdu_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q;

    // state register and iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ITER) cnt_q <= cnt_q + 1'b1;
            else                    cnt_q <= '0;
        end
    end

    // transitions and outputs
    always_comb begin
        state_d = state_q;
        busy    = 1'b0;
        load    = 1'b0;
        step    = 1'b0;
        fin     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = ST_ITER;
                end
            end
            ST_ITER: begin
                busy = 1'b1;
                step = 1'b1;
                if (cnt_q == LAST) state_d = ST_FIX;
            end
            ST_FIX: begin
                busy    = 1'b1;
                fin     = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R5: an accepted start makes the unit busy on the next cycle
    p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R5: completion cycle is followed by idle
    p_fin_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !busy);

    // R6: a start during the iteration phase does not end or restart the run
    p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !fin) |=> (busy && !load));

endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         fin,
    input  logic         op_div,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);

    localparam int AW = 2 * W + 1;

    logic          div_q, neg_res_q, neg_rem_q;
    logic [W-1:0]  dvs_q;
    logic [AW-1:0] acc_q, acc_step;
    logic [W-1:0]  hi_q, lo_q;

    logic [W-1:0]  mag_a, mag_b;
    assign mag_a = opa[W-1] ? (~opa + 1'b1) : opa;
    assign mag_b = opb[W-1] ? (~opb + 1'b1) : opb;

    // one iteration of either algorithm
    logic [W:0]    mul_upper;
    logic [W:0]    div_sh;
    logic [W+1:0]  div_trial;
    logic [W-1:0]  div_rem;
    logic          div_bit;

    always_comb begin
        mul_upper = acc_q[AW-1:W] + (acc_q[0] ? {1'b0, dvs_q} : '0);
        div_sh    = {acc_q[2*W-1:W], acc_q[W-1]};
        div_trial = {1'b0, div_sh} - {2'b00, dvs_q};
        div_bit   = ~div_trial[W+1];
        div_rem   = div_bit ? div_trial[W-1:0] : div_sh[W-1:0];
        if (div_q) acc_step = {1'b0, div_rem, acc_q[W-2:0], div_bit};
        else       acc_step = {1'b0, mul_upper, acc_q[W-1:1]};
    end

    // sign correction
    logic [2*W-1:0] prod_fix;
    logic [W-1:0]   quo_fix, rem_fix;

    always_comb begin
        prod_fix = neg_res_q ? (~acc_q[2*W-1:0] + 1'b1) : acc_q[2*W-1:0];
        quo_fix  = neg_res_q ? (~acc_q[W-1:0] + 1'b1)   : acc_q[W-1:0];
        rem_fix  = neg_rem_q ? (~acc_q[2*W-1:W] + 1'b1) : acc_q[2*W-1:W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q     <= 1'b0;
            neg_res_q <= 1'b0;
            neg_rem_q <= 1'b0;
            dvs_q     <= '0;
            acc_q     <= '0;
            hi_q      <= '0;
            lo_q      <= '0;
        end else begin
            if (load) begin
                div_q     <= op_div;
                neg_res_q <= opa[W-1] ^ opb[W-1];
                neg_rem_q <= opa[W-1];
                dvs_q     <= op_div ? mag_b : mag_a;
                acc_q     <= {{(W+1){1'b0}}, (op_div ? mag_a : mag_b)};
            end else if (step) begin
                acc_q <= acc_step;
            end
            if (fin) begin
                if (div_q) begin
                    hi_q <= rem_fix;
                    lo_q <= quo_fix;
                end else begin
                    hi_q <= prod_fix[2*W-1:W];
                    lo_q <= prod_fix[W-1:0];
                end
            end
        end
    end

    assign hi = hi_q;
    assign lo = lo_q;

    // R9: result registers move only on the completion cycle
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> ($stable(hi) && $stable(lo)));

    // R7: zero divisor yields an all-ones quotient magnitude
    p_zero_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && div_q && dvs_q == '0) |-> (acc_q[W-1:0] == {W{1'b1}}));

    // R4: restoring remainder magnitude stays below a nonzero divisor
    p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && div_q && dvs_q != '0) |-> (acc_q[2*W-1:W] < dvs_q));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_div,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);

    logic load, step, fin;

    muldiv_ctrl #(.ITERS(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .load  (load),
        .step  (step),
        .fin   (fin)
    );

    muldiv_dp #(.W(W)) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .fin    (fin),
        .op_div (op_div),
        .opa    (opa),
        .opb    (opb),
        .hi     (hi),
        .lo     (lo)
    );

endmodule

// File: tb/sim_muldiv_unit.sv
`timescale 1ns/1ps
module sim_muldiv_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_div = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        busy;
    logic [31:0] hi, lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    muldiv_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
        .opa(opa), .opb(opb), .busy(busy), .hi(hi), .lo(lo)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input bit dv, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, q, r;
        logic [31:0] amag;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (!dv) return 64'(sa * sb);
        if (b == 32'd0) begin
            amag = a[31] ? (~a + 1'b1) : a;
            return {a, (a[31] ? 32'd1 : 32'hFFFF_FFFF)};
        end
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
    endfunction

    // run one operation; inj: start pulses during the run with other operands
    task automatic run_op(input bit dv, input logic [31:0] a, input logic [31:0] b,
                          input bit inj, input string tag);
        logic [63:0] exp, prev;
        int n;
        exp  = model(dv, a, b);
        prev = {hi, lo};
        @(negedge clk);
        start = 1'b1; op_div = dv; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
        check({"R5 busy after start ", tag}, 64'(busy), 64'd1);
        n = 0;
        while (busy && n < 100) begin
            n++;
            opa = $urandom; opb = $urandom; op_div = ~dv;   // R10 disturbance
            if (n == 10) check({"R9 hold mid-run ", tag}, {hi, lo}, prev);
            if (inj && (n == 12 || n == 33)) start = 1'b1;  // R6
            @(negedge clk);
            start = 1'b0;
        end
        check({"R5 busy length ", tag}, 64'(n), 64'd33);
        check({"R2/R3/R4/R10 result ", tag}, {hi, lo}, exp);
        if (inj) begin
            @(negedge clk);
            check({"R6 stays idle ", tag}, 64'(busy), 64'd0);
            check({"R6 result kept ", tag}, {hi, lo}, exp);
        end
    endtask

    initial begin
        #20000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd12345));
        #1;
        check("R1 busy reset", 64'(busy), 64'd0);
        check("R1 hi/lo reset", {hi, lo}, 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {31'd0, busy, hi, lo}, 64'd0);

        run_op(1'b0, 32'd7, 32'd6, 1'b0, "R2 small mul");
        run_op(1'b0, 32'h8000_0000, 32'h8000_0000, 1'b1, "R2 minneg sq");
        run_op(1'b0, 32'hFFFF_FFFF, 32'd3, 1'b0, "R2 neg mul");
        run_op(1'b1, 32'd100, 32'd7, 1'b1, "R3 pos div");
        run_op(1'b1, 32'hFFFF_FF9C, 32'd7, 1'b0, "R4 neg dividend");
        run_op(1'b1, 32'd100, 32'hFFFF_FFF9, 1'b0, "R4 neg divisor");
        run_op(1'b1, 32'd12345, 32'd0, 1'b0, "R7 zero div pos");
        run_op(1'b1, 32'hFFFF_FF00, 32'd0, 1'b1, "R7 zero div neg");
        run_op(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R8 overflow");
        check("R8 explicit", {hi, lo}, {32'd0, 32'h8000_0000});

        for (int i = 0; i < 60; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            if (i % 4 == 1) b = b >> ($urandom % 31);
            if (i % 5 == 2) a = a >> ($urandom % 31);
            run_op(i[0], a, b, (i % 3 == 0), "random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule